// File: doc/BRIEF.md
# Display Engine Commit and Interrupt Sequencer

This block is the control front end of a display engine that can drive a panel in one of two ways. In continuous video mode, software writes a layer configuration word into a shadow register while frames keep streaming. It then asks for an update, and the block copies the shadow word into the active copy at the next frame start. In command mode there is no shadow stage: the active copy is loaded only when the run bit goes from 0 to 1. One frame is then sent, and the run bit clears itself when that frame ends.

The block also collects the engine's events into sticky interrupt status bits. These are stop or frame done, tearing effect, underflow, update done and vsync. A mask selects which bits drive the single interrupt line, and software clears bits by writing ones.

Pixel fetch and blending are outside the block. Their timing reaches it as frame-start, frame-end and underflow pulses. Software reaches the block through a simple single-cycle register bus whose read data is combinational.

Top module: `disp_commit_ctrl`

## Requirements
- R1: After reset, every register reads 0, `irq` and `engine_run` are low and `active_cfg` is 0.
- R2: In video mode (mode register at 0x08, bit 0 = 0), writing 1 to bit 0 (run) of the control register at 0x04 while idle copies the shadow word (written at 0x40) into `active_cfg` and sets `engine_run`. Shadow writes while running leave `active_cfg` unchanged.
- R3: In video mode while running, writing 1 to control bit 2 makes control bit 2 read 1. At the next `frame_start`, `active_cfg` takes the shadow word, control bit 2 clears and status bit 4 (update done) sets. The same write while idle is ignored.
- R4: In video mode while running, each `frame_start` sets status bit 5 (vsync).
- R5: In video mode while running, writing 1 to control bit 1 (stop) makes it read 1. At the next `frame_end`, run and stop clear and status bit 0 (done) sets.
- R6: In command mode (0x08 bit 0 = 1), `active_cfg` changes only on the run bit's 0-to-1 write. Shadow writes, update requests and `frame_start` while running change neither `active_cfg` nor the control bits, and `frame_start` sets no status bit.
- R7: In command mode, `frame_end` while running clears run and sets status bit 0.
- R8: The TE control register at 0x1F0 uses bit 8 to enable TE and bit 10 to select `te_pad` (1) or `te_int` (0). In command mode with TE enabled, a rising edge on the selected source sets status bit 1. Edges on the other source, or any edge in video mode, are ignored.
- R9: `underflow` while running sets status bit 2. `underflow` while idle is ignored.
- R10: Status bits (read at 0x1E8) stay set until a 1 is written to the same bit of 0x1E4. Writing 0xFF clears every bit. An event arriving in the same cycle as the clear of its bit leaves that bit set.
- R11: `irq` is high exactly when some status bit is set whose bit in the enable register at 0x1E0 is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| frame_end | input | 1 | One-cycle pulse at the end of a frame |
| underflow | input | 1 | Pixel pipeline starved this cycle |
| te_pad | input | 1 | Tearing-effect signal from the external pad |
| te_int | input | 1 | Tearing-effect signal from the internal source |
| irq | output | 1 | Interrupt request |
| engine_run | output | 1 | Engine is running |
| cmd_mode | output | 1 | Command mode selected |
| active_cfg | output | CFG_W | Configuration word in use by the engine |

## Verification
The hardest situation to reach is an update request that has to survive until a later frame start while other traffic keeps changing the shadow word and the status bits. The expected active word is then the shadow value at the frame start, not at the moment of the request. A seeded random phase interleaves shadow writes, update requests, frame starts, underflows, enable writes and partial clears. A bench model tracks the pending flag, the expected active word and the status bits. Directed steps cover the cases random traffic rarely hits: an event arriving in the same cycle as the clear of its bit, switching the TE source, and command-mode frames that must ignore update requests and shadow writes.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
    localparam int unsigned OFF_CTRL   = 'h004;
    localparam int unsigned OFF_MODE   = 'h008;
    localparam int unsigned OFF_SHADOW = 'h040;
    localparam int unsigned OFF_ACTIVE = 'h044;
    localparam int unsigned OFF_IEN    = 'h1E0;
    localparam int unsigned OFF_ICLR   = 'h1E4;
    localparam int unsigned OFF_ISTS   = 'h1E8;
    localparam int unsigned OFF_TECTL  = 'h1F0;

    localparam int ST_W    = 6;
    localparam int ST_DONE = 0;
    localparam int ST_TE   = 1;
    localparam int ST_ERR  = 2;
    localparam int ST_UPD  = 4;
    localparam int ST_VS   = 5;

    localparam int CTL_RUN  = 0;
    localparam int CTL_STOP = 1;
    localparam int CTL_UPD  = 2;
    localparam int TE_EN_BIT  = 8;
    localparam int TE_PAD_BIT = 10;
endpackage

// File: rtl/dcc_commit.sv
module dcc_commit #(
    parameter int CFG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_mode,
    input  logic             wr_shadow,
    input  logic [CFG_W-1:0] shadow_wdata,
    input  logic             wr_ctrl,
    input  logic [2:0]       ctrl_wdata,
    input  logic             frame_start,
    input  logic             frame_end,
    output logic             run_o,
    output logic             stop_pend_o,
    output logic             upd_pend_o,
    output logic [CFG_W-1:0] shadow_o,
    output logic [CFG_W-1:0] active_o,
    output logic             ev_done,
    output logic             ev_upd,
    output logic             ev_vsync
);
    import dcc_pkg::*;

    typedef struct packed {
        logic             run;
        logic             stop_pend;
        logic             upd_pend;
        logic [CFG_W-1:0] shadow;
        logic [CFG_W-1:0] active;
    } cst_t;

    cst_t st_d, st_q;
    logic start_d;
    logic swap_d;

    always_comb begin
        st_d     = st_q;
        ev_done  = 1'b0;
        ev_upd   = 1'b0;
        ev_vsync = 1'b0;
        start_d  = wr_ctrl && ctrl_wdata[CTL_RUN] && !st_q.run;
        swap_d   = 1'b0;
        if (wr_shadow) begin
            st_d.shadow = shadow_wdata;
        end
        if (start_d) begin
            st_d.run    = 1'b1;
            st_d.active = st_q.shadow;
        end else if (st_q.run) begin
            if (wr_ctrl && ctrl_wdata[CTL_STOP] && !cmd_mode) begin
                st_d.stop_pend = 1'b1;
            end
            if (wr_ctrl && ctrl_wdata[CTL_UPD] && !cmd_mode) begin
                st_d.upd_pend = 1'b1;
            end
            if (frame_start && !cmd_mode) begin
                ev_vsync = 1'b1;
                if (st_q.upd_pend) begin
                    swap_d        = 1'b1;
                    st_d.active   = st_q.shadow;
                    st_d.upd_pend = 1'b0;
                    ev_upd        = 1'b1;
                end
            end
            if (frame_end && (cmd_mode || st_q.stop_pend)) begin
                st_d.run       = 1'b0;
                st_d.stop_pend = 1'b0;
                st_d.upd_pend  = 1'b0;
                ev_done        = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o       = st_q.run;
    assign stop_pend_o = st_q.stop_pend;
    assign upd_pend_o  = st_q.upd_pend;
    assign shadow_o    = st_q.shadow;
    assign active_o    = st_q.active;

    // R2 and R6: the active word moves only on a run start or a video-mode swap
    assert_active_commit_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active != $past(st_q.active)) |-> $past(start_d || swap_d));

    // R3: an update-done event needs a running video-mode engine
    assert_upd_in_video_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_upd |-> (st_q.run && !cmd_mode && st_q.upd_pend));

    // R5 and R7: run only ends on a frame end
    assert_run_ends_at_frame_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.run) |-> $past(frame_end));

    // R3: a pending update only leaves at a frame boundary
    assert_upd_clears_at_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.upd_pend) |-> $past(frame_start || frame_end));
endmodule

// File: rtl/dcc_irq.sv
module dcc_irq (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_mode,
    input  logic                     te_en,
    input  logic                     te_sel_pad,
    input  logic                     te_pad,
    input  logic                     te_int,
    input  logic                     ev_done,
    input  logic                     ev_upd,
    input  logic                     ev_vsync,
    input  logic                     ev_err,
    input  logic                     wr_en,
    input  logic                     wr_clr,
    input  logic [dcc_pkg::ST_W-1:0] wdata,
    output logic [dcc_pkg::ST_W-1:0] en_o,
    output logic [dcc_pkg::ST_W-1:0] sts_o,
    output logic                     irq_o
);
    import dcc_pkg::*;

    typedef struct packed {
        logic [ST_W-1:0] en;
        logic [ST_W-1:0] sts;
        logic            te_prev;
    } ist_t;

    ist_t ir_d, ir_q;
    logic            te_src;
    logic            te_rise;
    logic [ST_W-1:0] set_vec;
    logic [ST_W-1:0] clr_vec;

    always_comb begin
        ir_d       = ir_q;
        te_src     = te_sel_pad ? te_pad : te_int;
        te_rise    = te_src && !ir_q.te_prev && te_en && cmd_mode;
        ir_d.te_prev = te_src;
        set_vec          = '0;
        set_vec[ST_DONE] = ev_done;
        set_vec[ST_TE]   = te_rise;
        set_vec[ST_ERR]  = ev_err;
        set_vec[ST_UPD]  = ev_upd;
        set_vec[ST_VS]   = ev_vsync;
        clr_vec  = wr_clr ? wdata : '0;
        ir_d.sts = (ir_q.sts & ~clr_vec) | set_vec;
        if (wr_en) begin
            ir_d.en = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_q <= '0;
        end else begin
            ir_q <= ir_d;
        end
    end

    assign en_o  = ir_q.en;
    assign sts_o = ir_q.sts;
    assign irq_o = |(ir_q.sts & ir_q.en);

    // R10: a status bit only drops after a clear write naming it
    assert_sticky_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(ir_q.sts) & ~ir_q.sts & ~$past(clr_vec)) == '0));

    // R8: tearing-effect status can only appear in enabled command mode
    assert_te_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_q.sts[ST_TE] && !$past(ir_q.sts[ST_TE])) |-> $past(cmd_mode && te_en));

    // R11: the line is low when nothing is enabled
    assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_q.en == '0) |-> !irq_o);
endmodule

// File: rtl/disp_commit_ctrl.sv
module disp_commit_ctrl #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int CFG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic              underflow,
    input  logic              te_pad,
    input  logic              te_int,
    output logic              irq,
    output logic              engine_run,
    output logic              cmd_mode,
    output logic [CFG_W-1:0]  active_cfg
);
    import dcc_pkg::*;

    typedef struct packed {
        logic cmd;
        logic te_en;
        logic te_pad_sel;
    } mst_t;

    mst_t ms_d, ms_q;
    logic wr, hit_ctrl, hit_mode, hit_shadow, hit_ien, hit_iclr, hit_tectl;
    logic run, stop_pend, upd_pend, ev_done, ev_upd, ev_vsync;
    logic [CFG_W-1:0] shadow;
    logic [ST_W-1:0]  en_v, sts_v;

    assign wr         = bus_sel && bus_we;
    assign hit_ctrl   = wr && (bus_addr == ADDR_W'(OFF_CTRL));
    assign hit_mode   = wr && (bus_addr == ADDR_W'(OFF_MODE));
    assign hit_shadow = wr && (bus_addr == ADDR_W'(OFF_SHADOW));
    assign hit_ien    = wr && (bus_addr == ADDR_W'(OFF_IEN));
    assign hit_iclr   = wr && (bus_addr == ADDR_W'(OFF_ICLR));
    assign hit_tectl  = wr && (bus_addr == ADDR_W'(OFF_TECTL));

    always_comb begin
        ms_d = ms_q;
        if (hit_mode) begin
            ms_d.cmd = bus_wdata[0];
        end
        if (hit_tectl) begin
            ms_d.te_en      = bus_wdata[TE_EN_BIT];
            ms_d.te_pad_sel = bus_wdata[TE_PAD_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms_q <= '0;
        end else begin
            ms_q <= ms_d;
        end
    end

    dcc_commit #(.CFG_W(CFG_W)) commit_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_mode     (ms_q.cmd),
        .wr_shadow    (hit_shadow),
        .shadow_wdata (bus_wdata[CFG_W-1:0]),
        .wr_ctrl      (hit_ctrl),
        .ctrl_wdata   (bus_wdata[2:0]),
        .frame_start  (frame_start),
        .frame_end    (frame_end),
        .run_o        (run),
        .stop_pend_o  (stop_pend),
        .upd_pend_o   (upd_pend),
        .shadow_o     (shadow),
        .active_o     (active_cfg),
        .ev_done      (ev_done),
        .ev_upd       (ev_upd),
        .ev_vsync     (ev_vsync)
    );

    dcc_irq irq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_mode   (ms_q.cmd),
        .te_en      (ms_q.te_en),
        .te_sel_pad (ms_q.te_pad_sel),
        .te_pad     (te_pad),
        .te_int     (te_int),
        .ev_done    (ev_done),
        .ev_upd     (ev_upd),
        .ev_vsync   (ev_vsync),
        .ev_err     (underflow && run),
        .wr_en      (hit_ien),
        .wr_clr     (hit_iclr),
        .wdata      (bus_wdata[ST_W-1:0]),
        .en_o       (en_v),
        .sts_o      (sts_v),
        .irq_o      (irq)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (int'(bus_addr))
            OFF_CTRL: begin
                bus_rdata[CTL_RUN]  = run;
                bus_rdata[CTL_STOP] = stop_pend;
                bus_rdata[CTL_UPD]  = upd_pend;
            end
            OFF_MODE:   bus_rdata[0] = ms_q.cmd;
            OFF_SHADOW: bus_rdata[CFG_W-1:0] = shadow;
            OFF_ACTIVE: bus_rdata[CFG_W-1:0] = active_cfg;
            OFF_IEN:    bus_rdata[ST_W-1:0] = en_v;
            OFF_ISTS:   bus_rdata[ST_W-1:0] = sts_v;
            OFF_TECTL: begin
                bus_rdata[TE_EN_BIT]  = ms_q.te_en;
                bus_rdata[TE_PAD_BIT] = ms_q.te_pad_sel;
            end
            default: bus_rdata = '0;
        endcase
    end

    assign engine_run = run;
    assign cmd_mode   = ms_q.cmd;

    // R1: the engine cannot be running straight out of reset without a write
    assert_run_needs_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> $past(hit_ctrl && bus_wdata[CTL_RUN]));
endmodule

// File: tb/disp_commit_ctrl_tb_top.sv
module disp_commit_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        frame_start = 1'b0, frame_end = 1'b0, underflow = 1'b0;
    logic        te_pad = 1'b0, te_int = 1'b0;
    logic        irq, engine_run, cmd_mode;
    logic [31:0] active_cfg;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_sts, exp_en, exp_act, exp_sh;
    logic        exp_pend;

    always #4 clk = ~clk;

    disp_commit_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .frame_start(frame_start), .frame_end(frame_end), .underflow(underflow),
        .te_pad(te_pad), .te_int(te_int), .irq(irq), .engine_run(engine_run),
        .cmd_mode(cmd_mode), .active_cfg(active_cfg)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: frame_start = 1'b1;
            1: frame_end = 1'b1;
            2: underflow = 1'b1;
            3: te_int = 1'b1;
            default: te_pad = 1'b1;
        endcase
        @(negedge clk);
        frame_start = 1'b0; frame_end = 1'b0; underflow = 1'b0;
        te_int = 1'b0; te_pad = 1'b0;
    endtask

    function automatic logic exp_irq(input logic [31:0] s, input logic [31:0] e);
        return |(s[5:0] & e[5:0]);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(12'h004, v); chk("R1 ctrl", v, 0);
        rd(12'h1E8, v); chk("R1 status", v, 0);
        rd(12'h1E0, v); chk("R1 enable", v, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 run", {31'd0, engine_run}, 0);
        chk("R1 active", active_cfg, 0);

        // R2 video run
        wr(12'h040, 32'hA5A5_0001);
        chk("R2 idle shadow write", active_cfg, 0);
        wr(12'h004, 32'h1);
        chk("R2 run loads", active_cfg, 32'hA5A5_0001);
        chk("R2 running", {31'd0, engine_run}, 1);
        wr(12'h040, 32'hB0B0_0002);
        chk("R2 shadow while running", active_cfg, 32'hA5A5_0001);

        // R3 update at frame start
        wr(12'h004, 32'h4);
        rd(12'h004, v); chk("R3 pending read", v, 32'h5);
        chk("R3 no early swap", active_cfg, 32'hA5A5_0001);
        pulse(0);
        chk("R3 swapped", active_cfg, 32'hB0B0_0002);
        rd(12'h004, v); chk("R3 self clear", v, 32'h1);
        rd(12'h1E8, v); chk("R3 R4 status", v, 32'h30);
        wr(12'h1E4, 32'hFF);
        rd(12'h1E8, v); chk("R10 clear all", v, 0);
        // R4 vsync on plain frame
        pulse(0);
        rd(12'h1E8, v); chk("R4 vsync only", v, 32'h20);
        // R11
        chk("R11 masked", {31'd0, irq}, 0);
        wr(12'h1E0, 32'h20);
        chk("R11 enabled", {31'd0, irq}, 1);
        wr(12'h1E4, 32'h20);
        chk("R11 cleared", {31'd0, irq}, 0);
        wr(12'h1E0, 32'h0);

        // R9 underflow while running
        pulse(2);
        rd(12'h1E8, v); chk("R9 underflow", v, 32'h04);
        // R10 set beats clear in the same cycle
        @(negedge clk);
        underflow = 1'b1; bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 12'h1E4; bus_wdata = 32'h04;
        @(negedge clk);
        underflow = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
        rd(12'h1E8, v); chk("R10 set wins", v, 32'h04);
        wr(12'h1E4, 32'h04);

        // R5 stop
        wr(12'h004, 32'h2);
        rd(12'h004, v); chk("R5 stop pending", v, 32'h3);
        pulse(0);
        chk("R5 still running", {31'd0, engine_run}, 1);
        pulse(1);
        chk("R5 stopped", {31'd0, engine_run}, 0);
        rd(12'h1E8, v); chk("R5 done status", v, 32'h21);
        wr(12'h1E4, 32'hFF);
        wr(12'h004, 32'h4);
        rd(12'h004, v); chk("R3 idle update ignored", v, 0);
        pulse(2);
        rd(12'h1E8, v); chk("R9 idle underflow ignored", v, 0);

        // R6 and R7 command mode
        wr(12'h008, 32'h1);
        chk("R6 mode out", {31'd0, cmd_mode}, 1);
        wr(12'h040, 32'hC0C0_0003);
        chk("R6 idle shadow", active_cfg, 32'hB0B0_0002);
        wr(12'h004, 32'h1);
        chk("R6 run latch", active_cfg, 32'hC0C0_0003);
        wr(12'h040, 32'hD0D0_0004);
        wr(12'h004, 32'h4);
        rd(12'h004, v); chk("R6 update ignored", v, 32'h1);
        pulse(0);
        chk("R6 no swap", active_cfg, 32'hC0C0_0003);
        rd(12'h1E8, v); chk("R6 no vsync", v, 0);
        pulse(1);
        chk("R7 self clear", {31'd0, engine_run}, 0);
        rd(12'h1E8, v); chk("R7 done", v, 32'h01);
        wr(12'h1E4, 32'hFF);
        wr(12'h004, 32'h1);
        chk("R6 second run", active_cfg, 32'hD0D0_0004);
        pulse(1);
        wr(12'h1E4, 32'hFF);

        // R8 tearing effect
        wr(12'h1F0, 32'h100);
        pulse(4);
        rd(12'h1E8, v); chk("R8 pad ignored on internal", v, 0);
        pulse(3);
        rd(12'h1E8, v); chk("R8 internal edge", v, 32'h02);
        wr(12'h1E4, 32'hFF);
        wr(12'h1F0, 32'h500);
        pulse(3);
        rd(12'h1E8, v); chk("R8 internal ignored on pad", v, 0);
        pulse(4);
        rd(12'h1E8, v); chk("R8 pad edge", v, 32'h02);
        wr(12'h1E4, 32'hFF);
        wr(12'h008, 32'h0);
        pulse(4);
        rd(12'h1E8, v); chk("R8 video ignored", v, 0);
        wr(12'h1F0, 32'h0);

        // random video traffic
        void'($urandom(32'd2024));
        exp_sh = 32'hD0D0_0004; exp_act = 32'hD0D0_0004;
        exp_sts = 0; exp_en = 0; exp_pend = 1'b0;
        wr(12'h004, 32'h1);
        chk("R2 random start", active_cfg, exp_act);
        for (int i = 0; i < 300; i++) begin
            int op;
            logic [31:0] r;
            op = int'($urandom_range(0, 5));
            r = $urandom;
            case (op)
                0: begin wr(12'h040, r); exp_sh = r; end
                1: begin wr(12'h004, 32'h4); exp_pend = 1'b1; end
                2: begin
                    pulse(0);
                    exp_sts[5] = 1'b1;
                    if (exp_pend) begin
                        exp_act = exp_sh; exp_pend = 1'b0; exp_sts[4] = 1'b1;
                    end
                end
                3: begin pulse(2); exp_sts[2] = 1'b1; end
                4: begin wr(12'h1E4, r); exp_sts = exp_sts & ~{26'd0, r[5:0]}; end
                default: begin wr(12'h1E0, r); exp_en = {26'd0, r[5:0]}; end
            endcase
            chk("R3 random active", active_cfg, exp_act);
            rd(12'h1E8, v); chk("R10 random status", v, exp_sts);
            rd(12'h004, v); chk("R3 random ctrl", v, {29'd0, exp_pend, 1'b0, 1'b1});
            chk("R11 random irq", {31'd0, irq}, {31'd0, exp_irq(exp_sts, exp_en)});
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule